// File: doc/BRIEF.md
# Two-Decade BCD Down Counter

This block is a presettable down counter whose state is held as binary-coded decimal digits, two by default (tens and units). On every rising clock edge it steps down by one when counting is enabled. When it steps below zero it wraps to the all-nines value. The count can be loaded from a parallel jam input in two ways. One is a load that waits for the next clock edge. The other is a load that takes effect at once, without a clock edge. A master clear sets the counter to its maximum count instead of zero. All control inputs are active-low.

The terminal count output is active-low. It is asserted only while the count is zero and counting is enabled, so it stays asserted for exactly one clock period. For longer counts, stages are chained. The terminal count of a lower stage drives the count enable of the next stage. The upper stage therefore steps down on the same edge at which the lower stage wraps from zero to its maximum.

Top module: `bcd_down_counter`

## Requirements
- R1: The count holds DIGITS decimal digits of 4 bits each, with the units digit in bits [3:0] and the next higher digit in bits [7:4]. The jam input uses the same layout.
- R2: On a rising clock edge with all loads and the clear inactive and the count enable low, the count drops by one. A digit at 0 becomes 9 and borrows from the next higher digit.
- R3: While the count enable is high and no load or clear is active, the count keeps its value across clock edges.
- R4: The terminal count output is low exactly when the count is all zeros and the count enable is low. It changes only with the count or the enable, so with the enable held low it stays low for one full clock period.
- R5: When the synchronous load input is low, the jam data becomes the count at the next rising clock edge, whatever the count enable is.
- R6: When the asynchronous load input goes low, the jam data becomes the count at once, without a clock edge, whatever the synchronous load and count enable are. While it stays low, every clock edge reloads the jam data.
- R7: When the clear input is low, the count is forced at once to the maximum value (every digit 9). Clear takes priority over both loads and over counting.
- R8: Stepping down from the all-zero count gives the all-nines count.
- R9: With the lower stage's terminal count driving the upper stage's count enable, two chained stages count down through one combined four-digit value. The upper terminal count is low only when the combined value is zero.
- R10: A digit loaded with a value above 9 decrements in binary when it would normally step, and it does not borrow. For example, units 0xC step to 0xB while the higher digit stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clearN | input | 1 | Asynchronous clear to maximum count, active-low |
| asyncLoadN | input | 1 | Asynchronous jam load, active-low |
| syncLoadN | input | 1 | Synchronous jam load on next edge, active-low |
| countEnN | input | 1 | Count enable, active-low |
| jamData | input | 4*DIGITS | Parallel BCD load value, units in low nibble |
| count | output | 4*DIGITS | Current BCD count, units in low nibble |
| termCountN | output | 1 | Terminal count, low when count is zero and enabled |

## Verification
Both bench instances keep the default DIGITS=2. They are chained lower-to-upper, so the reference model follows one combined value from 0 to 9999. This exposes the case where the whole chain wraps from 0000 to 9999. It also exposes the carry across stages, where the upper stage moves only on the edge at which the lower stage leaves zero. The single-stage value from 00 to 99 then covers wrap and borrow within one stage.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic load;
    logic dec;
  } ddc_strobe_t;

  function automatic logic [DIGIT_W-1:0] stepDigit(input logic [DIGIT_W-1:0] d);
    if (d == '0) return DIGIT_W'(9);
    return d - 1'b1;
  endfunction
endpackage

// File: rtl/ddc_control.sv
module ddc_control
  import ddc_pkg::*;
(
  input  logic        countEnN,
  input  logic        syncLoadN,
  input  logic        isZero,
  output ddc_strobe_t strobe,
  output logic        termCountN
);
  always_comb begin
    strobe.load = !syncLoadN;
    strobe.dec  = syncLoadN && !countEnN;
    termCountN  = !(isZero && !countEnN);
  end
endmodule

// File: rtl/ddc_datapath.sv
module ddc_datapath
  import ddc_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic                        clk,
  input  logic                        clearN,
  input  logic                        asyncLoadN,
  input  ddc_strobe_t                 strobe,
  input  logic [DIGITS*DIGIT_W-1:0]   jamData,
  output logic [DIGITS*DIGIT_W-1:0]   count,
  output logic                        isZero
);
  localparam int W = DIGITS * DIGIT_W;

  function automatic logic [W-1:0] allNines();
    logic [W-1:0] v;
    for (int i = 0; i < DIGITS; i++) v[i*DIGIT_W +: DIGIT_W] = DIGIT_W'(9);
    return v;
  endfunction

  localparam logic [W-1:0] MAX_COUNT = allNines();

  logic [DIGITS:0] borrow;
  logic [W-1:0]    stepped;
  logic [W-1:0]    nextCount;

  assign borrow[0] = strobe.dec;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [DIGIT_W-1:0] cur;
    assign cur = count[d*DIGIT_W +: DIGIT_W];
    assign stepped[d*DIGIT_W +: DIGIT_W] = borrow[d] ? stepDigit(cur) : cur;
    assign borrow[d+1] = borrow[d] && (cur == '0);
  end

  assign nextCount = strobe.load ? jamData : stepped;
  assign isZero    = (count == '0);

  always_ff @(posedge clk or negedge clearN or negedge asyncLoadN) begin
    if (!clearN)          count <= MAX_COUNT;
    else if (!asyncLoadN) count <= jamData;
    else                  count <= nextCount;
  end
endmodule

// File: rtl/bcd_down_counter.sv
module bcd_down_counter #(
  parameter int DIGITS = 2
) (
  input  logic                  clk,
  input  logic                  clearN,
  input  logic                  asyncLoadN,
  input  logic                  syncLoadN,
  input  logic                  countEnN,
  input  logic [DIGITS*4-1:0]   jamData,
  output logic [DIGITS*4-1:0]   count,
  output logic                  termCountN
);
  ddc_pkg::ddc_strobe_t strobe;
  logic isZero;

  ddc_control u_control (
    .countEnN  (countEnN),
    .syncLoadN (syncLoadN),
    .isZero    (isZero),
    .strobe    (strobe),
    .termCountN(termCountN)
  );

  ddc_datapath #(.DIGITS(DIGITS)) u_datapath (
    .clk       (clk),
    .clearN    (clearN),
    .asyncLoadN(asyncLoadN),
    .strobe    (strobe),
    .jamData   (jamData),
    .count     (count),
    .isZero    (isZero)
  );
endmodule

// File: rtl/ddc_checker.sv
module ddc_checker #(
  parameter int DIGITS = 2
) (
  input logic                clk,
  input logic                clearN,
  input logic                asyncLoadN,
  input logic                syncLoadN,
  input logic                countEnN,
  input logic [DIGITS*4-1:0] jamData,
  input logic [DIGITS*4-1:0] count,
  input logic                termCountN
);
  localparam int W = DIGITS * 4;

  function automatic logic [W-1:0] allNines();
    logic [W-1:0] v;
    for (int i = 0; i < DIGITS; i++) v[i*4 +: 4] = 4'd9;
    return v;
  endfunction

  localparam logic [W-1:0] MAX_COUNT = allNines();

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  assert_hold_R3: assert property (@(posedge clk)
    disable iff (!started || !clearN || !asyncLoadN)
    (countEnN && syncLoadN) |=> $stable(count));

  assert_sync_load_R5: assert property (@(posedge clk)
    disable iff (!started || !clearN || !asyncLoadN)
    !syncLoadN |=> (count == $past(jamData)));

  assert_tc_zero_R4: assert property (@(posedge clk)
    disable iff (!started)
    !termCountN |-> (count == '0 && !countEnN));

  assert_wrap_R8: assert property (@(posedge clk)
    disable iff (!started || !clearN || !asyncLoadN)
    (count == '0 && !countEnN && syncLoadN) |=> (count == MAX_COUNT));

  assert_clear_R7: assert property (@(posedge clk)
    disable iff (!started)
    !clearN |-> (count == MAX_COUNT));

  assert_async_load_R6: assert property (@(posedge clk)
    disable iff (!started || !clearN)
    (!asyncLoadN && $stable(jamData)) |-> (count == jamData));
endmodule

bind bcd_down_counter ddc_checker #(.DIGITS(DIGITS)) u_checker (
  .clk       (clk),
  .clearN    (clearN),
  .asyncLoadN(asyncLoadN),
  .syncLoadN (syncLoadN),
  .countEnN  (countEnN),
  .jamData   (jamData),
  .count     (count),
  .termCountN(termCountN)
);

// File: tb/bcd_down_counter_test.sv
module bcd_down_counter_test;
  logic clk = 1'b0;
  logic clearN, asyncLoadN, syncLoadN, countEnN;
  logic [7:0] jamLow, jamHigh;
  logic [7:0] countLow, countHigh;
  logic tcLow, tcHigh;

  int checks = 0;
  int failures = 0;
  int total;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bcd_down_counter uut (
    .clk(clk), .clearN(clearN), .asyncLoadN(asyncLoadN), .syncLoadN(syncLoadN),
    .countEnN(countEnN), .jamData(jamLow), .count(countLow), .termCountN(tcLow)
  );

  bcd_down_counter upperStage (
    .clk(clk), .clearN(clearN), .asyncLoadN(asyncLoadN), .syncLoadN(syncLoadN),
    .countEnN(tcLow), .jamData(jamHigh), .count(countHigh), .termCountN(tcHigh)
  );

  function automatic logic [7:0] toBcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int jamValue();
    return (jamHigh[7:4] * 10 + jamHigh[3:0]) * 100 + jamLow[7:4] * 10 + jamLow[3:0];
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, "low count", countLow, toBcd(total % 100));
    check(tag, "high count", countHigh, toBcd(total / 100));
    check(tag, "low tc", {7'd0, tcLow}, {7'd0, !((total % 100) == 0 && !countEnN)});
    check(tag, "high tc", {7'd0, tcHigh}, {7'd0, !(total == 0 && !countEnN)});
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    if (!clearN) total = 9999;
    else if (!asyncLoadN || !syncLoadN) total = jamValue();
    else if (!countEnN) total = (total == 0) ? 9999 : total - 1;
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clearN = 1'b0; asyncLoadN = 1'b1; syncLoadN = 1'b1; countEnN = 1'b0;
    jamLow = 8'h00; jamHigh = 8'h00; total = 9999;
    repeat (2) tick("R7");
    clearN = 1'b1;

    // R2, R9: combined chain counting down from 9999
    repeat (3) tick("R2");

    // R3: hold
    countEnN = 1'b1;
    repeat (3) tick("R3");

    // R5: synchronous load while enable is inactive, R1 layout
    jamHigh = 8'h00; jamLow = 8'h03; syncLoadN = 1'b0;
    tick("R5");
    syncLoadN = 1'b1; countEnN = 1'b0;
    // R4 terminal count at zero and R8 wrap through 0000
    repeat (5) tick("R4");

    // R9: lower stage borrow moves upper stage
    jamHigh = 8'h01; jamLow = 8'h00; syncLoadN = 1'b0;
    tick("R9");
    syncLoadN = 1'b1;
    repeat (3) tick("R9");
    countEnN = 1'b1;
    tick("R3");
    countEnN = 1'b0;

    // R6: asynchronous load without a clock edge
    #2;
    jamHigh = 8'h45; jamLow = 8'h67; asyncLoadN = 1'b0;
    #1;
    total = 4567;
    checkAll("R6");
    repeat (2) tick("R6");
    @(negedge clk);
    asyncLoadN = 1'b1;
    tick("R2");

    // R7: clear wins over asynchronous load, without a clock edge
    #2;
    asyncLoadN = 1'b0; clearN = 1'b0;
    #1;
    total = 9999;
    checkAll("R7");
    @(negedge clk);
    asyncLoadN = 1'b1; clearN = 1'b1;
    tick("R8");

    // R10: non-decimal units digit on the lower stage alone
    jamHigh = 8'h00; jamLow = 8'h1C; syncLoadN = 1'b0; countEnN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10", "loaded", countLow, 8'h1C);
    syncLoadN = 1'b1; countEnN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10", "first step", countLow, 8'h1B);
    @(posedge clk); @(negedge clk);
    check("R10", "second step", countLow, 8'h1A);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule